// File: doc/BRIEF.md
# Two-Wire Converter Serial Output Engine

This block is the digital side of a continuously converting 24-bit converter. It runs on the system clock and owns one output line that does two jobs. It falls low to announce a fresh conversion word. It then carries that word, most significant bit first, as the host toggles a serial clock input. The engine accepts one signed sample from a stand-in data source at the end of each conversion period. It clamps the sample to the 24-bit two's complement range and loads it for readout.

The host gives every command through the serial clock alone. The number of rising edges in a read cycle selects the action, and so does how long the clock is then held high. Extra edges after the word force the line high. A 26th edge requests a self-calibration. A long high level puts the engine to sleep. The next low level wakes it, with a calibration first if the hold began on the 25th edge. Every delay is a parameter counted in system clock cycles, so a bench can shorten all of them.

Top module: `conv_serial_link`

## Requirements
- R1: While reset is asserted, `line_o` is high. After reset is released, the engine runs a power-up calibration and delivers the first word CAL_CYC cycles later, within ±2 cycles.
- R2: In the cycle a word is taken (`sample_take_o` high), the engine captures `sample_i`, and from the next cycle `line_o` is low.
- R3: After a delivery, the first accepted rising edge of `sclk_i` puts bit 23 on `line_o`. Each later edge puts out the next lower bit, down to bit 0 on the 24th edge.
- R4: The delivered 24-bit word is `sample_i` read as signed SRC_W bits. It is clamped to 24'h7FFFFF when above +8388607 and to 24'h800000 when below -8388608.
- R5: After the 24th edge, `line_o` keeps the value of bit 0. A 25th rising edge drives it high, and it stays high until the next delivery.
- R6: Deliveries in normal running are exactly CONV_CYC cycles apart. During the last BLANK_CYC cycles of each period, `line_o` is high and rising edges are ignored. A word that is not read is replaced by the next one.
- R7: The falling edge that follows the 26th rising edge of a read cycle starts a calibration. `line_o` stays high, and the next word arrives CAL_CYC cycles (+0..6) after that falling edge.
- R8: `sclk_i` held high for SLEEP_CYC consecutive cycles while running puts the engine to sleep. In sleep, `line_o` is high and no word is delivered.
- R9: A low `sclk_i` in sleep wakes the engine. The first word follows WAKE_CYC cycles (+0..6) after the falling edge.
- R10: If the rising edge that began the sleep hold was the 25th of a read cycle, wakeup runs a calibration first. The first word then follows WAKE_CAL_CYC cycles (+0..6) after the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock, asynchronous to clk_i |
| sample_i | input | SRC_W | Signed sample from the data source |
| sample_take_o | output | 1 | High in the cycle the sample is captured |
| line_o | output | 1 | Combined ready flag and serial data output |

## Verification
The assertions assume that every high and low phase of `sclk_i` lasts several system clock cycles, so the two-stage synchronizer sees each edge exactly once. They also assume that `sample_i` is stable in the cycle it is taken. The stimulus uses high and low phases of eight cycles each. It changes `sample_i` only right after a take. It places every full read and every sleep hold well inside one conversion period, except for the deliberate edge driven into the blackout window.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,  // calibration or wakeup delay, line high
    ST_RUN   = 2'd1,  // continuous conversion
    ST_SLEEP = 2'd2
  } seq_st_e;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/code_clamp.sv
module code_clamp #(
  parameter int unsigned IN_W  = 26,
  parameter int unsigned OUT_W = 24
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic [OUT_W-1:0] code_o
);
  generate
    if (IN_W > OUT_W) begin : g_clamp
      logic [IN_W-OUT_W:0] top_bits;
      logic                fits;
      assign top_bits = raw_i[IN_W-1:OUT_W-1];
      assign fits     = (&top_bits) | ~(|top_bits);
      always_comb begin
        if (fits)               code_o = raw_i[OUT_W-1:0];
        else if (raw_i[IN_W-1]) code_o = {1'b1, {(OUT_W-1){1'b0}}};
        else                    code_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else if (IN_W < OUT_W) begin : g_extend
      assign code_o = {{(OUT_W-IN_W){raw_i[IN_W-1]}}, raw_i};
    end else begin : g_pass
      assign code_o = raw_i;
    end
  endgenerate
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int unsigned W     = 24,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     word_i,
  input  logic             shift_i,
  input  logic             blank_i,
  output logic             line_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(W);
  localparam logic [CNT_W-1:0] DONE  = CNT_W'(W + 2);
  localparam logic [CNT_W-1:0] SPENT = CNT_W'(W + 3);  // no word since reset

  logic [W-1:0]     sreg_q;
  logic             line_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      line_q <= 1'b1;
      cnt_q  <= SPENT;
    end else if (load_i) begin
      sreg_q <= word_i;
      line_q <= 1'b0;
      cnt_q  <= '0;
    end else if (blank_i) begin
      line_q <= 1'b1;
    end else if (shift_i) begin
      if (cnt_q < LAST) begin
        line_q <= sreg_q[W-1];
        sreg_q <= {sreg_q[W-2:0], 1'b0};
        cnt_q  <= cnt_q + CNT_W'(1);
      end else begin
        if (cnt_q == LAST) line_q <= 1'b1;
        if (cnt_q < DONE)  cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign line_o  = line_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/conv_serial_link.sv
module conv_serial_link
  import conv_port_pkg::*;
#(
  parameter int unsigned DATA_W       = 24,
  parameter int unsigned SRC_W        = 26,
  parameter int unsigned CONV_CYC     = 163840,
  parameter int unsigned BLANK_CYC    = 374,
  parameter int unsigned CAL_CYC      = 514867,
  parameter int unsigned SLEEP_CYC    = 163430,
  parameter int unsigned WAKE_CYC     = 175227,
  parameter int unsigned WAKE_CAL_CYC = 517325,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic [SRC_W-1:0] sample_i,
  output logic             sample_take_o,
  output logic             line_o
);
  localparam int unsigned LIM_A   = (CONV_CYC > CAL_CYC) ? CONV_CYC : CAL_CYC;
  localparam int unsigned LIM_B   = (WAKE_CYC > WAKE_CAL_CYC) ? WAKE_CYC : WAKE_CAL_CYC;
  localparam int unsigned MAX_LIM = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int unsigned TMR_W   = $clog2(MAX_LIM + 1);
  localparam int unsigned HOLD_W  = $clog2(SLEEP_CYC + 1);
  localparam int unsigned CNT_W   = $clog2(DATA_W + 4);

  localparam logic [TMR_W-1:0]  CONV_END    = TMR_W'(CONV_CYC - 1);
  localparam logic [TMR_W-1:0]  BLANK_START = TMR_W'(CONV_CYC - BLANK_CYC);
  localparam logic [TMR_W-1:0]  CAL_END     = TMR_W'(CAL_CYC - 1);
  localparam logic [TMR_W-1:0]  WAKE_END    = TMR_W'(WAKE_CYC - 1);
  localparam logic [TMR_W-1:0]  WCAL_END    = TMR_W'(WAKE_CAL_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_END    = HOLD_W'(SLEEP_CYC - 1);
  localparam logic [CNT_W-1:0]  CNT_LSB     = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_CAL     = CNT_W'(DATA_W + 2);

  logic              s_lvl, s_rise, s_fall;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  bit_cnt;

  seq_st_e           st_q, st_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d, lim_q, lim_d;
  logic [HOLD_W-1:0] hold_q;
  logic              arm_q;
  logic              blank, deliver, sleep_go, cal_go, shift_ok;

  sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sclk_i),
    .level_o (s_lvl),
    .rise_o  (s_rise),
    .fall_o  (s_fall)
  );

  code_clamp #(.IN_W(SRC_W), .OUT_W(DATA_W)) u_clamp (
    .raw_i  (sample_i),
    .code_o (word)
  );

  word_shifter #(.W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (deliver),
    .word_i  (word),
    .shift_i (s_rise & (st_q == ST_RUN)),
    .blank_i (blank),
    .line_o  (line_o),
    .count_o (bit_cnt)
  );

  always_comb begin
    blank    = (st_q != ST_RUN) || (tmr_q >= BLANK_START);
    shift_ok = s_rise && !blank;
    sleep_go = (st_q == ST_RUN) && s_lvl && (hold_q == HOLD_END);
    cal_go   = (st_q == ST_RUN) && s_fall && (bit_cnt == CNT_CAL);
    deliver  = ((st_q == ST_WAIT) && (tmr_q == lim_q)) ||
               ((st_q == ST_RUN) && (tmr_q == CONV_END) && !sleep_go && !cal_go);
  end

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q + TMR_W'(1);
    lim_d = lim_q;
    unique case (st_q)
      ST_WAIT: if (deliver) begin
        st_d  = ST_RUN;
        tmr_d = '0;
      end
      ST_RUN: begin
        if (sleep_go) begin
          st_d  = ST_SLEEP;
          tmr_d = '0;
        end else if (cal_go) begin
          st_d  = ST_WAIT;
          lim_d = CAL_END;
          tmr_d = '0;
        end else if (deliver) begin
          tmr_d = '0;
        end
      end
      ST_SLEEP: begin
        tmr_d = '0;
        if (!s_lvl) begin
          st_d  = ST_WAIT;
          lim_d = arm_q ? WCAL_END : WAKE_END;
        end
      end
      default: begin
        st_d  = ST_WAIT;
        lim_d = CAL_END;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_WAIT;
      tmr_q  <= '0;
      lim_q  <= CAL_END;   // calibration at power-up
      hold_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      lim_q <= lim_d;
      if ((st_q == ST_RUN) && s_lvl) begin
        if (hold_q != HOLD_END) hold_q <= hold_q + HOLD_W'(1);
      end else begin
        hold_q <= '0;
      end
      // set when the 25th edge is taken; any fall disarms
      if (s_fall)                                                     arm_q <= 1'b0;
      else if (shift_ok && (st_q == ST_RUN) && (bit_cnt == CNT_LSB)) arm_q <= 1'b1;
    end
  end

  assign sample_take_o = deliver;
endmodule

// File: rtl/conv_serial_link_chk.sv
module conv_serial_link_chk
  import conv_port_pkg::*;
#(
  parameter int unsigned TMR_W     = 18,
  parameter int unsigned CONV_CYC  = 163840,
  parameter int unsigned BLANK_CYC = 374
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_i,
  input logic             take_i,
  input seq_st_e          st_i,
  input logic [TMR_W-1:0] tmr_i
);
  localparam logic [TMR_W-1:0] BLANK_START = TMR_W'(CONV_CYC - BLANK_CYC);

  p_ready_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !line_i);

  p_take_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !take_i);

  p_blank_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_RUN) && (tmr_i > BLANK_START)) |-> line_i);

  p_wait_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_WAIT) && !take_i) |=> line_i);

  p_sleep_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SLEEP) |=> line_i);
endmodule

bind conv_serial_link conv_serial_link_chk #(
  .TMR_W     (TMR_W),
  .CONV_CYC  (CONV_CYC),
  .BLANK_CYC (BLANK_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .line_i (line_o),
  .take_i (sample_take_o),
  .st_i   (st_q),
  .tmr_i  (tmr_q)
);

// File: tb/conv_serial_link_test.sv
`timescale 1ns/1ps
module conv_serial_link_test;
  localparam int DW    = 24;
  localparam int SW    = 26;
  localparam int CONV  = 1000;
  localparam int BLANK = 20;
  localparam int CAL   = 700;
  localparam int SLEEP = 200;
  localparam int WAKE  = 250;
  localparam int WCAL  = 900;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sclk_i = 1'b0;
  logic [SW-1:0] sample_i = '0;
  logic          take, line;

  always #4 clk_i = ~clk_i;

  conv_serial_link #(
    .DATA_W(DW), .SRC_W(SW), .CONV_CYC(CONV), .BLANK_CYC(BLANK), .CAL_CYC(CAL),
    .SLEEP_CYC(SLEEP), .WAKE_CYC(WAKE), .WAKE_CAL_CYC(WCAL), .SYNC_STAGES(2)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sample_i(sample_i),
    .sample_take_o(take), .line_o(line)
  );

  int unsigned cyc = 0, last_take = 0, take_cnt = 0;
  int unsigned n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (take) begin
      last_take <= cyc;
      take_cnt  <= take_cnt + 1;
    end
  end

  function automatic logic [DW-1:0] sat(input logic [SW-1:0] v);
    int sv;
    sv = 32'($signed(v));
    if (sv > 8388607)  return 24'h7FFFFF;
    if (sv < -8388608) return 24'h800000;
    return v[DW-1:0];
  endfunction

  function automatic logic [SW-1:0] rnd();
    logic [31:0] r;
    r = $urandom();
    if (r[31]) return SW'($urandom());
    return {{(SW-DW){r[23]}}, r[23:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse();
    sclk_i = 1'b1; tick(8);
    sclk_i = 1'b0; tick(8);
  endtask

  task automatic read_word(output logic [DW-1:0] w);
    w = '0;
    for (int i = 0; i < DW; i++) begin
      sclk_i = 1'b1; tick(6);
      w = {w[DW-2:0], line};
      tick(2);
      sclk_i = 1'b0; tick(8);
    end
  endtask

  task automatic wait_take();
    int unsigned t;
    t = take_cnt;
    while (take_cnt == t) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    logic [DW-1:0] w, expw;
    logic [SW-1:0] dir [6];
    int unsigned t0, prev, tc, d;
    void'($urandom(32'd4242));
    dir[0] = 26'h1FFFFFF; dir[1] = 26'h2000000; dir[2] = 26'h07FFFFF;
    dir[3] = 26'h3800000; dir[4] = 26'h0800000; dir[5] = 26'h37FFFFF;

    sample_i = rnd();
    tick(5);
    chk(line == 1'b1, "R1 reset line", 32'(line), 32'd1);
    rst_ni = 1'b1;
    t0 = cyc;
    wait_take();
    d = last_take - t0;
    chk(d + 2 >= CAL && d <= CAL + 2, "R1 power-up delay", d, CAL);
    chk(line == 1'b0, "R2 ready low", 32'(line), 32'd0);
    expw = sat(sample_i);
    sample_i = rnd();
    read_word(w);
    chk(w == expw, "R3 word", w, expw);
    tick(20);
    chk(line == expw[0], "R5 hold lsb", 32'(line), 32'(expw[0]));
    pulse();
    chk(line == 1'b1, "R5 25th high", 32'(line), 32'd1);

    // random words then clamp corners
    for (int k = 0; k < 11; k++) begin
      prev = last_take;
      wait_take();
      chk(last_take - prev == CONV, "R6 period", last_take - prev, CONV);
      chk(line == 1'b0, "R2 ready low", 32'(line), 32'd0);
      expw = sat(sample_i);
      sample_i = (k < 5) ? rnd() : dir[k-5];
      read_word(w);
      chk(w == expw, (k < 6) ? "R3 word" : "R4 clamp", w, expw);
      pulse();
      chk(line == 1'b1, "R5 25th high", 32'(line), 32'd1);
    end
    chk(sat(26'h1FFFFFF) == 24'h7FFFFF && sat(26'h2000000) == 24'h800000, "R4 model", 0, 0);

    // blackout: even word, edge inside window ignored
    wait_take();
    expw = sat(sample_i);
    sample_i = rnd() & ~SW'(1);
    read_word(w);
    chk(w == expw, "R4 clamp", w, expw);
    wait_take();
    expw = sat(sample_i);
    sample_i = rnd();
    read_word(w);
    chk(w == expw && w[0] == 1'b0, "R3 even word", w, expw);
    while (cyc < last_take + CONV - BLANK + 4) @(negedge clk_i);
    chk(line == 1'b1, "R6 blackout high", 32'(line), 32'd1);
    sclk_i = 1'b1; tick(6);
    chk(line == 1'b1, "R6 blackout edge", 32'(line), 32'd1);
    sclk_i = 1'b0;

    // overwrite: skip one word
    wait_take();
    sample_i = rnd();
    wait_take();
    expw = sat(sample_i);
    sample_i = rnd();
    read_word(w);
    chk(w == expw, "R6 overwrite", w, expw);

    // calibration on 26th falling edge
    pulse();
    sclk_i = 1'b1; tick(8);
    sclk_i = 1'b0;
    t0 = cyc; tc = take_cnt;
    tick(CAL / 2);
    chk(line == 1'b1 && take_cnt == tc, "R7 cal line", 32'(line), 32'd1);
    wait_take();
    d = last_take - t0;
    chk(d >= CAL && d <= CAL + 6, "R7 cal delay", d, CAL);
    expw = sat(sample_i);
    sample_i = rnd();
    read_word(w);
    chk(w == expw, "R7 word after cal", w, expw);

    // sleep without calibration
    wait_take();
    tc = take_cnt;
    repeat (3) pulse();
    sclk_i = 1'b1;
    tick(SLEEP + 2 * CONV);
    chk(take_cnt == tc, "R8 no delivery", take_cnt - tc, 0);
    chk(line == 1'b1, "R8 sleep line", 32'(line), 32'd1);
    expw = sat(sample_i);
    sclk_i = 1'b0;
    t0 = cyc;
    wait_take();
    d = last_take - t0;
    chk(d >= WAKE && d <= WAKE + 6, "R9 wake delay", d, WAKE);
    sample_i = rnd();
    read_word(w);
    chk(w == expw, "R9 word after wake", w, expw);

    // sleep hold on the 25th edge: calibrate at wakeup
    pulse();
    wait_take();
    expw = sat(sample_i);
    read_word(w);
    chk(w == expw, "R3 word", w, expw);
    sclk_i = 1'b1;
    tick(SLEEP + 100);
    chk(line == 1'b1, "R10 sleep line", 32'(line), 32'd1);
    sample_i = rnd();
    expw = sat(sample_i);
    sclk_i = 1'b0;
    t0 = cyc;
    wait_take();
    d = last_take - t0;
    chk(d >= WCAL && d <= WCAL + 6, "R10 wake cal delay", d, WCAL);
    read_word(w);
    chk(w == expw, "R10 word after cal", w, expw);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      summary();
      $finish;
    end
  end
endmodule